// File: doc/BRIEF.md
# Frequency-Change Watchdog with Safe Fallback

This block protects a clock synthesizer while software experiments with a new output frequency. Software picks the frequency either from the board straps, captured while reset is held, or from a 5-bit software code. It may also turn on step-less (M/N) programming. Before it commits a risky setting, software arms a countdown in units of a slow tick. A prescaler divides the reference clock to make that tick, nominally 250 ms. If software does not disarm or re-arm in time, the block drops step-less mode and reverts the frequency selection to a known-good source. That source is the captured strap code or a stored safe code, chosen by a control bit. The block also holds the system reset output low for a fixed number of ticks.

The register bus has a 2-bit address, a write strobe and an 8-bit registered read port. The live countdown value is visible through the depth register while the watchdog runs.

Top module: `wdg_freq_guard`

## Requirements
- R1: After synchronous reset, `freq_code` equals the captured strap code, `stepless_en` is 0 and `sys_rst_n` is 1. The depth register (address 2) reads 8 and the watchdog register (address 1) reads 0.
- R2: The control register (address 0) holds the select bit in bit 0, the safe-source bit in bit 1, the step-less bit in bit 2 and the software code in bits 7:3. `freq_code` equals the software code when the select bit is 1, and the strap code otherwise.
- R3: A write to address 1 with bit 7 set loads the countdown from the depth field and clears the timeout flag, also when the countdown is already running. Bits 4:0 of that write always store the safe code.
- R4: Once armed with depth D ≥ 1, the watchdog expires exactly D·TICK_DIV clock cycles after the arming write. With depth 0 it expires after TICK_DIV cycles.
- R5: Address 2 reads the remaining count in bits 6:0 while the watchdog runs, and the programmed depth otherwise.
- R6: Address 1 reads bit 7 = 1 while counting and bit 6 = 1 once the watchdog has expired; bits 4:0 read the safe code. Both bit 7 and bit 6 are never 1 at the same time.
- R7: On expiry `sys_rst_n` goes low on the expiry cycle and stays low for exactly RST_TICKS·TICK_DIV cycles.
- R8: On expiry with the safe-source bit at 0, the select bit is cleared, so `freq_code` returns to the strap code.
- R9: On expiry with the safe-source bit at 1, the stored safe code is copied into the software code and selected.
- R10: Expiry clears the step-less bit, and `stepless_en` falls on the expiry cycle.
- R11: A write to address 1 with bit 7 clear stops the countdown without an expiry. The timeout flag keeps its value.
- R12: The strap code is captured only while reset is asserted. Later changes on `strap_code` do not affect `freq_code`, or the strap readback at address 3, bits 4:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset; straps are sampled while high |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Registered read data for `cfg_addr` |
| strap_code | input | 5 | Board strap frequency code |
| freq_code | output | 5 | Resolved frequency selection |
| stepless_en | output | 1 | Step-less M/N programming enable |
| sys_rst_n | output | 1 | Active-low system reset request (open-drain pull-down when 0) |

## Verification
The hardest situations to reach from the ports are the exact expiry cycle and a re-arm that lands just before expiry. Both depend on where the prescaler phase sits relative to the arming write. The bench runs the block with a 16-cycle tick, so the tick is short enough to step through. Because arming restarts the prescaler, every expiry edge can be predicted from the write cycle alone. Each scenario samples `sys_rst_n`, `freq_code` and `stepless_en` one cycle before and on the predicted edge. It then reads the depth register mid-count to see the live value.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int BUS_W   = 8;
  localparam int CODE_W  = 5;
  localparam int DEPTH_W = 7;
  localparam int ADDR_W  = 2;
  localparam logic [DEPTH_W-1:0] DEPTH_RST = 7'd8;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 2'd0,
    A_WDOG  = 2'd1,
    A_DEPTH = 2'd2,
    A_STRAP = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/wdg_tick.sv
module wdg_tick #(
  parameter int TICK_DIV = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst || restart) pre_q <= '0;
    else if (pre_q == LAST) pre_q <= '0;
    else pre_q <= pre_q + 1'b1;
  end

  // restart aligns the tick phase with the arming write
  assign tick = (pre_q == LAST) && !restart;
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
  import wdg_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               arm_set,
  input  logic               arm_clr,
  input  logic [DEPTH_W-1:0] load_val,
  input  logic               tick,
  output logic               running,
  output logic               expired,
  output logic [DEPTH_W-1:0] count,
  output logic               fire
);
  // expiry when the last count unit elapses; depth 0 expires on the first tick
  assign fire = running && tick && !arm_set && !arm_clr && (count <= DEPTH_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      expired <= 1'b0;
      count   <= '0;
    end else if (arm_set) begin
      running <= 1'b1;
      expired <= 1'b0;
      count   <= load_val;
    end else if (arm_clr) begin
      running <= 1'b0;
    end else if (fire) begin
      running <= 1'b0;
      expired <= 1'b1;
      count   <= '0;
    end else if (running && tick) begin
      count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/wdg_rst_pulse.sv
module wdg_rst_pulse #(
  parameter int PULSE_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic sys_rst_n
);
  localparam int CW = $clog2(PULSE_CYC + 1);
  localparam logic [CW-1:0] START = CW'(PULSE_CYC - 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q    <= '0;
      sys_rst_n <= 1'b1;
    end else if (fire) begin
      left_q    <= START;
      sys_rst_n <= 1'b0;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end else begin
      sys_rst_n <= 1'b1;
    end
  end
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BUS_W-1:0]   wdata,
  input  logic [CODE_W-1:0]  strap_pins,
  input  logic               fire,
  input  logic               running,
  input  logic               expired,
  input  logic [DEPTH_W-1:0] count,
  output logic               arm_set,
  output logic               arm_clr,
  output logic [DEPTH_W-1:0] depth_q,
  output logic [BUS_W-1:0]   rdata,
  output logic [CODE_W-1:0]  freq_code,
  output logic               stepless_en,
  output logic               safe_src,
  output logic [CODE_W-1:0]  safe_code,
  output logic [CODE_W-1:0]  strap_q
);
  reg_addr_e        a;
  logic             sw_sel_q;
  logic [CODE_W-1:0] sw_code_q;
  logic [BUS_W-1:0] rd_nxt;
  logic             wr_ctrl, wr_wdog, wr_depth;

  assign a        = reg_addr_e'(addr);
  assign wr_ctrl  = wr_en && (a == A_CTRL);
  assign wr_wdog  = wr_en && (a == A_WDOG);
  assign wr_depth = wr_en && (a == A_DEPTH);
  assign arm_set  = wr_wdog &&  wdata[BUS_W-1];
  assign arm_clr  = wr_wdog && !wdata[BUS_W-1];

  // straps follow the pins only while reset is held
  always_ff @(posedge clk) begin
    if (rst) strap_q <= strap_pins;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_sel_q    <= 1'b0;
      safe_src    <= 1'b0;
      stepless_en <= 1'b0;
      sw_code_q   <= '0;
      safe_code   <= '0;
      depth_q     <= DEPTH_RST;
    end else begin
      if (wr_ctrl) begin
        sw_sel_q    <= wdata[0];
        safe_src    <= wdata[1];
        stepless_en <= wdata[2];
        sw_code_q   <= wdata[BUS_W-1:3];
      end
      if (wr_wdog)  safe_code <= wdata[CODE_W-1:0];
      if (wr_depth) depth_q   <= wdata[DEPTH_W-1:0];
      // expiry overrides a same-cycle control write
      if (fire) begin
        stepless_en <= 1'b0;
        if (safe_src) begin
          sw_sel_q  <= 1'b1;
          sw_code_q <= safe_code;
        end else begin
          sw_sel_q  <= 1'b0;
        end
      end
    end
  end

  assign freq_code = sw_sel_q ? sw_code_q : strap_q;

  always_comb begin
    unique case (a)
      A_CTRL:  rd_nxt = {sw_code_q, stepless_en, safe_src, sw_sel_q};
      A_WDOG:  rd_nxt = {running, expired, 1'b0, safe_code};
      A_DEPTH: rd_nxt = {1'b0, running ? count : depth_q};
      default: rd_nxt = {{(BUS_W-CODE_W){1'b0}}, strap_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_nxt;
  end
endmodule

// File: rtl/wdg_freq_guard.sv
module wdg_freq_guard
  import wdg_pkg::*;
#(
  parameter int TICK_DIV  = 6250000,
  parameter int RST_TICKS = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [BUS_W-1:0]   cfg_wdata,
  output logic [BUS_W-1:0]   cfg_rdata,
  input  logic [CODE_W-1:0]  strap_code,
  output logic [CODE_W-1:0]  freq_code,
  output logic               stepless_en,
  output logic               sys_rst_n
);
  localparam int PULSE_CYC = TICK_DIV * RST_TICKS;

  logic               arm_set, arm_clr, tick, fire;
  logic               running, expired, safe_src;
  logic [DEPTH_W-1:0] count, depth_q;
  logic [CODE_W-1:0]  safe_code, strap_q;

  wdg_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .strap_pins(strap_code), .fire(fire), .running(running), .expired(expired),
    .count(count), .arm_set(arm_set), .arm_clr(arm_clr), .depth_q(depth_q),
    .rdata(cfg_rdata), .freq_code(freq_code), .stepless_en(stepless_en),
    .safe_src(safe_src), .safe_code(safe_code), .strap_q(strap_q)
  );

  wdg_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .restart(arm_set), .tick(tick)
  );

  wdg_counter u_cnt (
    .clk(clk), .rst(rst), .arm_set(arm_set), .arm_clr(arm_clr),
    .load_val(depth_q), .tick(tick), .running(running), .expired(expired),
    .count(count), .fire(fire)
  );

  wdg_rst_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk(clk), .rst(rst), .fire(fire), .sys_rst_n(sys_rst_n)
  );
endmodule

// File: rtl/wdg_chk.sv
module wdg_chk
  import wdg_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               fire,
  input logic               arm_set,
  input logic               running,
  input logic               expired,
  input logic [DEPTH_W-1:0] count,
  input logic               safe_src,
  input logic [CODE_W-1:0]  safe_code,
  input logic [CODE_W-1:0]  strap_q,
  input logic [CODE_W-1:0]  freq_code,
  input logic               stepless_en,
  input logic               sys_rst_n
);
  p_count_down_r5: assert property (@(posedge clk) disable iff (rst)
    (running && !arm_set) |=> (count <= $past(count)));

  p_run_flag_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(running && expired));

  p_rst_drop_r7: assert property (@(posedge clk) disable iff (rst)
    fire |=> !sys_rst_n);

  p_rst_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst_n) |-> $past(fire));

  p_strap_reload_r8: assert property (@(posedge clk) disable iff (rst)
    (fire && !safe_src) |=> (freq_code == strap_q));

  p_safe_reload_r9: assert property (@(posedge clk) disable iff (rst)
    (fire && safe_src) |=> (freq_code == $past(safe_code)));

  p_stepless_off_r10: assert property (@(posedge clk) disable iff (rst)
    fire |=> !stepless_en);

  p_expire_flag_r6: assert property (@(posedge clk) disable iff (rst)
    fire |=> (expired && !running));

  p_strap_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(strap_q));
endmodule

bind wdg_freq_guard wdg_chk u_chk (
  .clk(clk), .rst(rst), .fire(fire), .arm_set(arm_set), .running(running),
  .expired(expired), .count(count), .safe_src(safe_src), .safe_code(safe_code),
  .strap_q(strap_q), .freq_code(freq_code), .stepless_en(stepless_en),
  .sys_rst_n(sys_rst_n)
);

// File: tb/sim_wdg_freq_guard.sv
`timescale 1ns/1ps
module sim_wdg_freq_guard;
  localparam int TD = 16;
  localparam int RT = 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [7:0] cfg_wdata = 8'd0;
  logic [7:0] cfg_rdata;
  logic [4:0] strap_code = 5'h13;
  logic [4:0] freq_code;
  logic       stepless_en, sys_rst_n;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  wdg_freq_guard #(.TICK_DIV(TD), .RST_TICKS(RT)) u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .strap_code(strap_code),
    .freq_code(freq_code), .stepless_en(stepless_en), .sys_rst_n(sys_rst_n)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    cfg_addr = a;
    @(posedge clk); @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    strap_code = 5'h13; rst = 1'b1;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    check("R1 freq_code", freq_code, 5'h13);
    check("R1 stepless", stepless_en, 0);
    check("R1 sys_rst_n", sys_rst_n, 1);
    rd(2'd2, d); check("R1 depth reset", d, 8);
    rd(2'd1, d); check("R1 wdog reset", d, 0);
    strap_code = 5'h0A;
    cyc(3);
    check("R12 freq after pin change", freq_code, 5'h13);
    rd(2'd3, d); check("R12 strap readback", d, 8'h13);
  endtask

  task automatic t_select();
    wr(2'd0, {5'h07, 1'b0, 1'b0, 1'b1});
    check("R2 software code", freq_code, 5'h07);
    wr(2'd0, {5'h07, 1'b0, 1'b0, 1'b0});
    check("R2 strap code", freq_code, 5'h13);
  endtask

  task automatic t_live_and_stop();
    logic [7:0] d;
    bit seen_low = 0;
    wr(2'd2, 8'd5);
    wr(2'd1, 8'h80);
    rd(2'd1, d); check("R6 running readback", d, 8'h80);
    cyc(TD - 1);
    rd(2'd2, d); check("R5 live count", d, 4);
    wr(2'd1, 8'h00);
    rd(2'd1, d); check("R11 stopped", d, 0);
    rd(2'd2, d); check("R5 programmed depth", d, 5);
    for (int i = 0; i < 6 * TD; i++) begin
      cyc(1);
      if (!sys_rst_n) seen_low = 1;
    end
    check("R11 no expiry after stop", seen_low, 0);
  endtask

  task automatic t_expire_strap();
    logic [7:0] d;
    int low;
    wr(2'd0, {5'h07, 1'b1, 1'b0, 1'b1});
    check("R10 stepless set", stepless_en, 1);
    wr(2'd2, 8'd3);
    wr(2'd1, 8'h80);
    cyc(3 * TD - 1);
    check("R4 not yet expired", sys_rst_n, 1);
    check("R2 code before expiry", freq_code, 5'h07);
    cyc(1);
    check("R4 expiry edge", sys_rst_n, 0);
    check("R8 strap reload", freq_code, 5'h13);
    check("R10 stepless cleared", stepless_en, 0);
    low = 1;
    for (int i = 0; i < 100 && !sys_rst_n; i++) begin
      cyc(1);
      if (!sys_rst_n) low++;
    end
    check("R7 pulse length", low, TD * RT);
    rd(2'd1, d); check("R6 expired flag", d, 8'h40);
    rd(2'd2, d); check("R5 depth after expiry", d, 3);
    rd(2'd0, d); check("R8 control after expiry", d, {5'h07, 3'b000});
  endtask

  task automatic t_expire_safe();
    logic [7:0] d;
    wr(2'd0, 8'h02);
    wr(2'd2, 8'd0);
    wr(2'd1, 8'h9B);
    cyc(TD - 1);
    check("R4 depth0 not yet", sys_rst_n, 1);
    cyc(1);
    check("R4 depth0 expiry", sys_rst_n, 0);
    check("R9 safe reload", freq_code, 5'h1B);
    cyc(TD + 2);
    rd(2'd1, d); check("R6 flag with safe code", d, 8'h5B);
    wr(2'd1, 8'h9B);
    rd(2'd1, d); check("R3 rearm clears flag", d, 8'h9B);
    wr(2'd1, 8'h1B);
    rd(2'd1, d); check("R11 flag kept at 0 on stop", d, 8'h1B);
  endtask

  task automatic t_rearm();
    wr(2'd2, 8'd2);
    wr(2'd1, 8'h80);
    cyc(TD + 8);
    wr(2'd1, 8'h80);
    cyc(2 * TD - 1);
    check("R3 rearm reload delays expiry", sys_rst_n, 1);
    cyc(1);
    check("R3 expiry after reload", sys_rst_n, 0);
    cyc(TD + 2);
    check("R7 released", sys_rst_n, 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_select();
        t_live_and_stop();
        t_expire_strap();
        t_expire_safe();
        t_rearm();
      end
      begin
        #400000;
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule